// File: doc/BRIEF.md
# Floppy Controller Command-Phase Sequencer

This block is the processor side of a floppy disk controller's byte handshake. It has two ports: a read-only status port and a data port. Software writes a command as a run of bytes to the data port. The block looks at the first byte, works out how many parameter bytes that command still needs, and collects them. After the last parameter byte it hands the command to an execution stub. The stub does the real work and returns a result block together with a done pulse. The block then returns result bytes through the data port, one per read, and the number of bytes depends on the command.

The status port tells software what the block expects next. One bit says the data port is ready for a transfer. Another gives the direction of that transfer, and others flag the execution phase and a busy controller. The drive busy flags are passed straight through from an input. A byte that does not decode as a known command skips execution and returns a one-byte error result. The controller accepts no new command until the processor has read every result byte.

Top module: `fdc_cmd_seq`

## Requirements
- R1: The status byte is {ready, direction, exec, busy, drv_busy[3:0]}, with the ready flag in bit 7, direction in bit 6 (1 = controller to processor), execution in bit 5, busy in bit 4 and the drive flags in bits 3..0. After reset the status reads 0x80 with drv_busy in the low nibble.
- R2: Only the low five bits of the first command byte select the command. Its top three bits appear on `exe_flags` (byte bit 7 on flag bit 2), and the five-bit code appears on `exe_opcode` during execution.
- R3: The total number of command bytes, opcode included, is as follows. Codes 00110, 01100, 00101, 01001, 00010, 10001, 11001 and 11101 take 9 bytes. Code 01101 takes 6, codes 01010, 00111 and 00100 take 2, codes 00011 and 01111 take 3, and code 01000 takes 1. The parameter bytes appear on `exe_params` in arrival order, byte k at bits 8k+7..8k, and unused slots read zero.
- R4: `exe_start` is high for exactly one cycle, the cycle after the last command byte is accepted.
- R5: During execution the status shows exec=1, busy=1 and ready=0. The phase lasts until `exe_done` is high at a clock edge.
- R6: The result length is 7 bytes for the 9-byte commands and for 01101 and 01010, 2 bytes for 01000 and 1 byte for 00100. Results are `exe_result` as sampled at done, byte 0 (bits 7..0) first. After the last result byte is read the block is idle (status 0x80 | drv_busy).
- R7: Commands 00011, 01111 and 00111 have no result bytes. The block goes idle at the edge where done is seen.
- R8: An unknown code skips execution (no `exe_start`) and enters the result phase with the single byte 0x80.
- R9: A data-port write during the result phase is ignored and does not change the next result byte. A data-port read outside the result phase returns 0.
- R10: Each data-port access made while ready=1 clears ready for the following cycle. Ready returns the cycle after that unless the block has entered execution.
- R11: `exe_done` has no effect outside the execution phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Access strobe, one cycle per transfer |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 1 | 0 = status port, 1 = data port |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (status or result byte), combinational |
| drv_busy | input | 4 | Drive busy flags shown in status bits 3..0 |
| exe_start | output | 1 | One-cycle start pulse to the execution stub |
| exe_opcode | output | 5 | Decoded five-bit command code |
| exe_flags | output | 3 | Top three bits of the command byte |
| exe_params | output | 8*NPARAM | Collected parameter bytes |
| exe_done | input | 1 | Execution finished, results valid |
| exe_result | input | 8*NRES | Result bytes, byte 0 in the low bits |

## Verification
The assertions check the handshake shape on every cycle: ready drops after each accepted data access and comes back, execution and direction are never shown together, the start pulse occurs only in execution and lasts one cycle, and a write during the result phase leaves the pending result byte unchanged. The per-command byte counts, the parameter order, the result contents and count, the no-result commands, the invalid-code path and the ignored `exe_done` are shown only by the bench. It drives random and directed command sequences and compares them with its own table.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_EXEC = 2'd2,
        PH_RES  = 2'd3
    } phase_t;

    localparam int LEN_W = 4;

    typedef struct packed {
        logic             known;
        logic [LEN_W-1:0] cmd_len;
        logic [LEN_W-1:0] res_len;
    } opc_info_t;

    localparam logic [7:0] ST0_BAD_CMD = 8'h80;

endpackage

// File: rtl/fdc_opc_decode.sv
module fdc_opc_decode
    import fdc_seq_pkg::*;
(
    input  logic [4:0] opc,
    output opc_info_t  info
);
    always_comb begin
        info = '0;
        unique case (opc)
            5'b00110, 5'b01100, 5'b00101, 5'b01001,
            5'b00010, 5'b10001, 5'b11001, 5'b11101: info = '{1'b1, 4'd9, 4'd7};
            5'b01101: info = '{1'b1, 4'd6, 4'd7};
            5'b01010: info = '{1'b1, 4'd2, 4'd7};
            5'b00011: info = '{1'b1, 4'd3, 4'd0};
            5'b01111: info = '{1'b1, 4'd3, 4'd0};
            5'b00111: info = '{1'b1, 4'd2, 4'd0};
            5'b01000: info = '{1'b1, 4'd1, 4'd2};
            5'b00100: info = '{1'b1, 4'd2, 4'd1};
            default:  info = '0;
        endcase
    end
endmodule

// File: rtl/fdc_msr_build.sv
module fdc_msr_build #(
    parameter int NDRV = 4
) (
    input  logic            rqm,
    input  logic            dio,
    input  logic            exm,
    input  logic            busy,
    input  logic [NDRV-1:0] drv,
    output logic [7:0]      msr
);
    localparam int PAD = 4 - NDRV;

    generate
        if (PAD > 0) begin : g_pad
            assign msr = {rqm, dio, exm, busy, {PAD{1'b0}}, drv};
        end else begin : g_full
            assign msr = {rqm, dio, exm, busy, drv[3:0]};
        end
    endgenerate
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int NPARAM = 8,
    parameter int NRES   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_sel,
    input  logic                cpu_wr,
    input  logic                cpu_addr,
    input  logic [7:0]          cpu_wdata,
    output logic [7:0]          cpu_rdata,
    input  logic [3:0]          drv_busy,
    output logic                exe_start,
    output logic [4:0]          exe_opcode,
    output logic [2:0]          exe_flags,
    output logic [8*NPARAM-1:0] exe_params,
    input  logic                exe_done,
    input  logic [8*NRES-1:0]   exe_result
);
    localparam int CW = $clog2(NPARAM + 2);

    typedef struct packed {
        phase_t                  ph;
        logic [CW-1:0]           cnt;
        logic [CW-1:0]           clen;
        logic [CW-1:0]           rlen;
        logic [4:0]              opc;
        logic [2:0]              flg;
        logic [NPARAM-1:0][7:0]  prm;
        logic [NRES-1:0][7:0]    res;
        logic                    hold;
        logic                    start;
    } seq_state_t;

    seq_state_t s_d, s_q;
    opc_info_t  info;
    logic       rqm, acc, wr_acc, rd_acc;
    logic [7:0] msr, res_byte;

    fdc_opc_decode u_dec (
        .opc  (cpu_wdata[4:0]),
        .info (info)
    );

    fdc_msr_build #(.NDRV(4)) u_msr (
        .rqm  (rqm),
        .dio  (s_q.ph == PH_RES),
        .exm  (s_q.ph == PH_EXEC),
        .busy (s_q.ph != PH_IDLE),
        .drv  (drv_busy),
        .msr  (msr)
    );

    always_comb begin
        rqm    = !s_q.hold && (s_q.ph != PH_EXEC);
        acc    = cpu_sel && cpu_addr && rqm;
        wr_acc = acc && cpu_wr;
        rd_acc = acc && !cpu_wr;

        res_byte = 8'h00;
        for (int i = 0; i < NRES; i++) begin
            if (CW'(i) == s_q.cnt) res_byte = s_q.res[i];
        end

        s_d       = s_q;
        s_d.hold  = acc;
        s_d.start = 1'b0;

        unique case (s_q.ph)
            PH_IDLE: begin
                if (wr_acc) begin
                    s_d.opc  = cpu_wdata[4:0];
                    s_d.flg  = cpu_wdata[7:5];
                    s_d.prm  = '0;
                    s_d.cnt  = CW'(1);
                    s_d.clen = CW'(info.cmd_len);
                    s_d.rlen = CW'(info.res_len);
                    if (!info.known) begin
                        s_d.ph     = PH_RES;
                        s_d.cnt    = '0;
                        s_d.rlen   = CW'(1);
                        s_d.res    = '0;
                        s_d.res[0] = ST0_BAD_CMD;
                    end else if (info.cmd_len == LEN_W'(1)) begin
                        s_d.ph    = PH_EXEC;
                        s_d.start = 1'b1;
                    end else begin
                        s_d.ph = PH_CMD;
                    end
                end
            end
            PH_CMD: begin
                if (wr_acc) begin
                    for (int i = 0; i < NPARAM; i++) begin
                        if (CW'(i) + CW'(1) == s_q.cnt) s_d.prm[i] = cpu_wdata;
                    end
                    s_d.cnt = s_q.cnt + CW'(1);
                    if (s_q.cnt + CW'(1) == s_q.clen) begin
                        s_d.ph    = PH_EXEC;
                        s_d.start = 1'b1;
                    end
                end
            end
            PH_EXEC: begin
                if (exe_done) begin
                    s_d.cnt = '0;
                    if (s_q.rlen == '0) begin
                        s_d.ph = PH_IDLE;
                    end else begin
                        s_d.ph  = PH_RES;
                        s_d.res = exe_result;
                    end
                end
            end
            PH_RES: begin
                if (rd_acc) begin
                    s_d.cnt = s_q.cnt + CW'(1);
                    if (s_q.cnt + CW'(1) == s_q.rlen) s_d.ph = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_rdata  = cpu_addr ? ((s_q.ph == PH_RES) ? res_byte : 8'h00) : msr;
    assign exe_start  = s_q.start;
    assign exe_opcode = s_q.opc;
    assign exe_flags  = s_q.flg;
    assign exe_params = s_q.prm;

endmodule

// File: rtl/fdc_seq_chk.sv
module fdc_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_sel,
    input logic       cpu_wr,
    input logic       cpu_addr,
    input logic [7:0] msr,
    input logic       exe_start,
    input logic [7:0] res_byte
);
    a_r10_rqm_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_addr && msr[7]) |=> !msr[7]);

    a_r10_rqm_back: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr[7] && !msr[5]) |=> msr[7]);

    a_r5_exec_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        msr[5] |-> (!msr[7] && msr[4]));

    a_r1_dir_exec_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(msr[6:5]) <= 1);

    a_r4_start_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exe_start |-> msr[5]);

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        exe_start |=> !exe_start);

    a_r9_res_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (msr[6] && cpu_sel && cpu_addr && cpu_wr) |=> (msr[6] && $stable(res_byte)));
endmodule

bind fdc_cmd_seq fdc_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .msr       (msr),
    .exe_start (exe_start),
    .res_byte  (res_byte)
);

// File: tb/sim_fdc_cmd_seq.sv
module sim_fdc_cmd_seq;
    localparam int NP = 8;
    localparam int NR = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic [3:0]    drv = 4'hA;
    logic          start;
    logic [4:0]    eop;
    logic [2:0]    efl;
    logic [8*NP-1:0] eprm;
    logic          done = 1'b0;
    logic [8*NR-1:0] eres = '0;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fdc_cmd_seq #(.NPARAM(NP), .NRES(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(sel), .cpu_wr(wr), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_rdata(rdata), .drv_busy(drv),
        .exe_start(start), .exe_opcode(eop), .exe_flags(efl), .exe_params(eprm),
        .exe_done(done), .exe_result(eres)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void exp_len(input logic [4:0] o, output bit kn, output int cl, output int rl);
        kn = 1; cl = 0; rl = 0;
        case (o)
            5'b00110, 5'b01100, 5'b00101, 5'b01001,
            5'b00010, 5'b10001, 5'b11001, 5'b11101: begin cl = 9; rl = 7; end
            5'b01101: begin cl = 6; rl = 7; end
            5'b01010: begin cl = 2; rl = 7; end
            5'b00011, 5'b01111: begin cl = 3; rl = 0; end
            5'b00111: begin cl = 2; rl = 0; end
            5'b01000: begin cl = 1; rl = 2; end
            5'b00100: begin cl = 2; rl = 1; end
            default:  begin kn = 0; cl = 1; rl = 1; end
        endcase
    endfunction

    function automatic logic [4:0] pick_valid(input int k);
        case (k)
            0: return 5'b00110;  1: return 5'b01100;  2: return 5'b00101;
            3: return 5'b01001;  4: return 5'b00010;  5: return 5'b01010;
            6: return 5'b01101;  7: return 5'b10001;  8: return 5'b11001;
            9: return 5'b11101; 10: return 5'b00011; 11: return 5'b01111;
           12: return 5'b00111; 13: return 5'b01000; default: return 5'b00100;
        endcase
    endfunction

    task automatic wait_rqm();
        addr = 1'b0;
        #1;
        while (rdata[7] == 1'b0) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        wait_rqm();
        sel = 1'b1; wr = 1'b1; addr = 1'b1; wdata = b;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; addr = 1'b0;
        #1;
        chk(rdata[7] == 1'b0, "R10 ready low after write", rdata, 0);
    endtask

    task automatic rd_byte(output logic [7:0] b);
        wait_rqm();
        sel = 1'b1; wr = 1'b0; addr = 1'b1;
        #1;
        b = rdata;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; addr = 1'b0;
        #1;
        chk(rdata[7] == 1'b0, "R10 ready low after read", rdata, 0);
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [8*NP-1:0] prm,
                           input logic [8*NR-1:0] res, input bit junk);
        bit kn; int cl, rl;
        logic [7:0] b;
        exp_len(op[4:0], kn, cl, rl);
        wr_byte(op);
        if (!kn) begin
            chk(rdata[6:4] == 3'b101, "R8 result phase entered", rdata[6:4], 5);
            chk(start == 1'b0, "R8 no start pulse", start, 0);
            if (junk) wr_byte(8'h3C);
            rd_byte(b);
            chk(b == 8'h80, "R8 invalid result byte", b, 8'h80);
            wait_rqm();
            chk(rdata == {4'h8, drv}, "R6 idle after invalid", rdata, {4'h8, drv});
            return;
        end
        if (cl > 1) begin
            chk(rdata[6:4] == 3'b001, "R3 command phase status", rdata[6:4], 1);
            if (junk) begin
                rd_byte(b);
                chk(b == 8'h00, "R9 read in command phase", b, 0);
            end
            for (int i = 1; i < cl; i++) begin
                chk(start == 1'b0 && rdata[5] == 1'b0, "R3 not yet executing", rdata, 0);
                wr_byte(prm[8*(i-1) +: 8]);
            end
        end
        chk(start == 1'b1, "R4 start pulse", start, 1);
        chk(rdata[7] == 1'b0 && rdata[5:4] == 2'b11, "R5 exec status", rdata, 8'h30);
        chk(eop == op[4:0], "R2 opcode", eop, op[4:0]);
        chk(efl == op[7:5], "R2 flags", efl, op[7:5]);
        for (int i = 0; i < NP; i++) begin
            logic [7:0] e;
            e = (i < cl - 1) ? prm[8*i +: 8] : 8'h00;
            chk(eprm[8*i +: 8] == e, "R3 parameter byte", eprm[8*i +: 8], e);
        end
        @(negedge clk); #1;
        chk(start == 1'b0, "R4 start one cycle", start, 0);
        repeat (2) @(negedge clk);
        #1;
        chk(rdata[7:5] == 3'b001, "R5 still executing", rdata, 8'h20);
        eres = res;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        #1;
        if (rl == 0) begin
            chk(rdata == {4'h8, drv}, "R7 idle with no result", rdata, {4'h8, drv});
        end else begin
            chk(rdata[7:4] == 4'hD, "R6 result phase status", rdata[7:4], 4'hD);
            if (junk) wr_byte(~res[7:0]);
            for (int i = 0; i < rl; i++) begin
                rd_byte(b);
                chk(b == res[8*i +: 8], "R6 result byte", b, res[8*i +: 8]);
            end
            wait_rqm();
            chk(rdata == {4'h8, drv}, "R6 idle after results", rdata, {4'h8, drv});
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rdata == 8'h8A, "R1 reset status", rdata, 8'h8A);
        drv = 4'h5;
        #1;
        chk(rdata == 8'h85, "R1 drive flags pass through", rdata, 8'h85);

        // R11: done while idle has no effect
        eres = {NR{8'hEE}};
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        #1;
        chk(rdata == 8'h85, "R11 done ignored in idle", rdata, 8'h85);
        rd_byte(b);
        chk(b == 8'h00, "R11 no result after stray done", b, 0);
        wait_rqm();
        chk(rdata == 8'h85, "R11 still idle", rdata, 8'h85);

        // directed corner cases
        run_cmd(8'h1F, '0, '0, 1'b1);                       // R8 unknown code
        run_cmd(8'h00, '0, '0, 1'b0);                       // R8 unknown code
        run_cmd(8'h08, '0, 56'h0000_0000_0000_3320, 1'b1);  // R6 two results
        run_cmd(8'h04, 64'h05, 56'h71, 1'b1);               // R6 one result
        run_cmd(8'h0F, 64'h28_01, '0, 1'b0);                // R7 seek
        run_cmd(8'hE6, 64'h0102030405060708, 56'hA1A2A3A4A5A6A7, 1'b1); // R2 flags

        for (int n = 0; n < 80; n++) begin
            logic [7:0] op;
            logic [8*NP-1:0] prm;
            logic [8*NR-1:0] res;
            int k;
            k = $urandom_range(0, 16);
            op = (k == 16) ? 8'($urandom) : {3'($urandom), pick_valid(k)};
            prm = {$urandom, $urandom};
            res = {24'($urandom), $urandom};
            drv = 4'($urandom);
            run_cmd(op, prm, res, 1'($urandom));
        end
        finish_run();
    end
endmodule